// File: doc/BRIEF.md
# SECDED Hamming Codeword Decoder

This block checks a stored Hamming codeword as it is read back and delivers a clean data word. It recomputes the check bits from the received data field and forms a syndrome. From the syndrome and an overall parity bit it finds a single flipped bit and corrects it, or it flags a double error as uncorrectable. A 2-bit status travels beside the data. Correction happens only on the output path. The caller owns the stored copy and decides whether to scrub it.

Three parameters shape the block. The first sets the data width. The second turns double-error detection on (the default) or off; with it off, the block behaves as a single-error corrector without the overall parity bit. The third adds an output register stage for timing, which moves the latency from 2 to 3 clock cycles. A new codeword can be presented every cycle.

Top module: `ecc_secded_dec`

## Requirements
- R1: Codeword layout for DATA_W data bits and CHK_W Hamming check bits (CHK_W is the smallest p with 2^p >= DATA_W+p+1; 6 for 32 bits):
  - Data occupies codeword bits [DATA_W-1:0].
  - Check bit k sits at codeword bit DATA_W+k.
  - With detection on, the overall parity bit is the top bit DATA_W+CHK_W.
  - Data bit j takes Hamming position q_j. The sequence q_0, q_1, ... is the integers from 3 upward in ascending order with the powers of two skipped.
  - Check bit k covers every data bit whose position has bit k set.
  - The parity bit makes the whole codeword even.
- R2: The status output uses 00 for no error, 01 for one error and 10 for two errors. The value 11 never appears.
- R3: A codeword with exactly one data bit flipped yields the original data with status 01.
- R4: A single flip confined to one Hamming check bit, or to the overall parity bit, yields status 01 with the data field passed through unchanged.
- R5: With detection on, any two flipped bits yield status 10, and the output data is the received data field without correction.
- R6: A syndrome naming a position above DATA_W+CHK_W yields status 10 with the data uncorrected. This holds in both detection modes.
- R7: With no extra stage, a codeword applied before clock edge k appears at the outputs after edge k+1. With the extra stage enabled, it appears after edge k+2.
- R8: With detection off, there is no parity bit. A zero syndrome gives status 00, and an in-range non-zero syndrome gives status 01 with the named bit corrected.
- R9: While the active-low reset is asserted, the data output is zero and the status is 00. The reset is asynchronous.
- R10: Codewords applied on consecutive cycles each emerge, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_i | input | CW_W | Received codeword: data, check bits, optional parity |
| data_o | output | DATA_W | Corrected or passed-through data word |
| err_o | output | 2 | Error status: 00 none, 01 single, 10 double |

## Verification
The default configuration is tried with five kinds of codeword:
- Clean codewords with all-zero, all-one and mixed data give status 00.
- Single flips at the lowest and highest data bit must be corrected.
- Single flips on a check bit and on the parity bit exercise the path where the status reports an error but the data is left alone.
- Pairs of flips (data with data, data with check, data with parity) must give status 10 with raw data.
- A three-bit pattern whose syndrome lands beyond the codeword separates the range test from the parity test.

A detection-off instance shows single correction and the out-of-range case without a parity bit. An instance with the extra stage, driven with one isolated error word, shows exactly where the result appears. A back-to-back stream shows one result per cycle.

// File: rtl/ecc_dec_pkg.sv
package ecc_dec_pkg;

   typedef enum logic [1:0] {
      ERR_NONE = 2'b00,
      ERR_ONE  = 2'b01,
      ERR_TWO  = 2'b10
   } err_code_e;

   // smallest p such that 2^p covers DATA_W + p positions plus the zero syndrome
   function automatic int chk_width(input int n);
      int p;
      p = 1;
      while ((1 << p) < (n + p + 1)) p++;
      return p;
   endfunction

   // Hamming position of data bit j: j-th non power of two, counting from 3
   function automatic int data_pos(input int j);
      int p;
      int c;
      p = 2;
      c = -1;
      while (c < j) begin
         p++;
         if ((p & (p - 1)) != 0) c++;
      end
      return p;
   endfunction

endpackage

// File: rtl/ecc_syndrome_gen.sv
module ecc_syndrome_gen #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   parameter bit DED_EN = 1'b1,
   localparam int CW_W  = DATA_W + CHK_W + (DED_EN ? 1 : 0)
) (
   input  logic [CW_W-1:0]   cw,
   output logic [CHK_W-1:0]  syn,
   output logic              par_odd,
   output logic [DATA_W-1:0] dat
);

   assign dat = cw[DATA_W-1:0];

   // XOR array: one tree per check bit over the data bits it covers
   for (genvar k = 0; k < CHK_W; k++) begin : g_chk
      logic [DATA_W-1:0] tap;
      for (genvar j = 0; j < DATA_W; j++) begin : g_tap
         localparam int POS = ecc_dec_pkg::data_pos(j);
         if (((POS >> k) & 1) != 0) begin : g_on
            assign tap[j] = cw[j];
         end else begin : g_off
            assign tap[j] = 1'b0;
         end
      end
      assign syn[k] = cw[DATA_W+k] ^ (^tap);
   end

   if (DED_EN) begin : g_par
      assign par_odd = ^cw;
   end else begin : g_nopar
      assign par_odd = 1'b0;
   end

endmodule

// File: rtl/ecc_bit_locator.sv
module ecc_bit_locator #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 6,
   parameter bit DED_EN = 1'b1
) (
   input  logic [CHK_W-1:0]      syn,
   input  logic                  par_odd,
   output logic [DATA_W-1:0]     flip,
   output ecc_dec_pkg::err_code_e status
);
   import ecc_dec_pkg::*;

   localparam int LAST_POS = DATA_W + CHK_W;

   logic [DATA_W-1:0] hit;
   logic              syn_zero;
   logic              in_range;
   logic              fix;

   // error-bit locator: one comparator per data bit
   for (genvar j = 0; j < DATA_W; j++) begin : g_loc
      localparam logic [CHK_W-1:0] POS_V = CHK_W'(data_pos(j));
      assign hit[j] = (syn == POS_V);
   end

   assign syn_zero = (syn == '0);
   assign in_range = (int'(syn) <= LAST_POS);

   if (DED_EN) begin : g_secded
      always_comb begin
         fix    = 1'b0;
         status = ERR_NONE;
         if (syn_zero) begin
            status = par_odd ? ERR_ONE : ERR_NONE;
         end else if (!par_odd) begin
            status = ERR_TWO;
         end else if (!in_range) begin
            status = ERR_TWO;
         end else begin
            status = ERR_ONE;
            fix    = 1'b1;
         end
      end
   end else begin : g_sec
      logic unused_par;
      assign unused_par = par_odd;
      always_comb begin
         fix    = 1'b0;
         status = ERR_NONE;
         if (!syn_zero) begin
            if (in_range) begin
               status = ERR_ONE;
               fix    = 1'b1;
            end else begin
               status = ERR_TWO;
            end
         end
      end
   end

   assign flip = fix ? hit : '0;

endmodule

// File: rtl/ecc_pipe_reg.sv
module ecc_pipe_reg #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (EN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
   parameter int DATA_W     = 32,
   parameter bit DED_EN     = 1'b1,
   parameter bit EXTRA_PIPE = 1'b0,
   localparam int CHK_W     = ecc_dec_pkg::chk_width(DATA_W),
   localparam int CW_W      = DATA_W + CHK_W + (DED_EN ? 1 : 0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   cw_i,
   output logic [DATA_W-1:0] data_o,
   output logic [1:0]        err_o
);
   import ecc_dec_pkg::*;

   initial begin
      assert (DATA_W >= 8 && DATA_W <= 1024)
         else $error("DATA_W %0d outside 8..1024", DATA_W);
      assert (CHK_W >= 4 && CHK_W <= 11)
         else $error("derived CHK_W %0d unexpected", CHK_W);
   end

   // stage 1: XOR array, registered
   logic [CHK_W-1:0]  syn_c,  syn_q;
   logic              par_c,  par_q;
   logic [DATA_W-1:0] dat_c,  dat_q;

   ecc_syndrome_gen #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .DED_EN (DED_EN)
   ) u_syn (
      .cw      (cw_i),
      .syn     (syn_c),
      .par_odd (par_c),
      .dat     (dat_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_q <= '0;
         par_q <= 1'b0;
         dat_q <= '0;
      end else begin
         syn_q <= syn_c;
         par_q <= par_c;
         dat_q <= dat_c;
      end
   end

   // stage 2: locate, correct, register
   logic [DATA_W-1:0] flip;
   err_code_e         stat_c;
   logic [DATA_W-1:0] out_data_q;
   logic [1:0]        out_err_q;

   ecc_bit_locator #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .DED_EN (DED_EN)
   ) u_loc (
      .syn     (syn_q),
      .par_odd (par_q),
      .flip    (flip),
      .status  (stat_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data_q <= '0;
         out_err_q  <= ERR_NONE;
      end else begin
         out_data_q <= dat_q ^ flip;
         out_err_q  <= stat_c;
      end
   end

   // optional stage 3
   logic [DATA_W+1:0] tail_q;

   ecc_pipe_reg #(
      .W  (DATA_W + 2),
      .EN (EXTRA_PIPE)
   ) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({out_err_q, out_data_q}),
      .q     (tail_q)
   );

   assign data_o = tail_q[DATA_W-1:0];
   assign err_o  = tail_q[DATA_W+1:DATA_W];

   // assertions guarding the correction stage
   p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_err_q != 2'b11);

   p_one_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flip));

   p_single_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_err_q == ERR_ONE) |-> ($countones(out_data_q ^ $past(dat_q)) <= 1));

   p_double_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_err_q == ERR_TWO) |-> (out_data_q == $past(dat_q)));

   p_clean_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_err_q == ERR_NONE) |-> (out_data_q == $past(dat_q)));

   p_quiet_syn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_q == '0 && !par_q) |=> (out_err_q == ERR_NONE));

endmodule

// File: tb/ecc_secded_dec_bench.sv
`timescale 1ns/1ps
module ecc_secded_dec_bench;

   localparam int BW = 32;
   localparam int BC = 6;
   localparam int BD = BW + BC + 1;   // 39
   localparam int BS = BW + BC;       // 38

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [BD-1:0] cw_d = '0;
   logic [BS-1:0] cw_s = '0;
   logic [BW-1:0] dat_m, dat_s, dat_p;
   logic [1:0]    err_m, err_s, err_p;

   ecc_secded_dec #(.DATA_W(BW), .DED_EN(1'b1), .EXTRA_PIPE(1'b0)) u_ecc_secded_dec (
      .clk(clk), .rst_n(rst_n), .cw_i(cw_d), .data_o(dat_m), .err_o(err_m));
   ecc_secded_dec #(.DATA_W(BW), .DED_EN(1'b0), .EXTRA_PIPE(1'b0)) u_sec (
      .clk(clk), .rst_n(rst_n), .cw_i(cw_s), .data_o(dat_s), .err_o(err_s));
   ecc_secded_dec #(.DATA_W(BW), .DED_EN(1'b1), .EXTRA_PIPE(1'b1)) u_pipe (
      .clk(clk), .rst_n(rst_n), .cw_i(cw_d), .data_o(dat_p), .err_o(err_p));

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int bpos(input int j);
      int p;
      int c;
      p = 2;
      c = -1;
      while (c < j) begin
         p++;
         if ((p & (p - 1)) != 0) c++;
      end
      return p;
   endfunction

   // reference encoder built from R1
   function automatic logic [BD-1:0] enc(input logic [BW-1:0] d);
      logic [BC-1:0] c;
      c = '0;
      for (int j = 0; j < BW; j++)
         for (int k = 0; k < BC; k++)
            if (((bpos(j) >> k) & 1) != 0) c[k] = c[k] ^ d[j];
      return {^{c, d}, c, d};
   endfunction

   localparam logic [BW-1:0] T_DATA [10] = '{
      32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678, 32'hDEAD_BEEF,
      32'h0F0F_F0F0, 32'hCAFE_F00D, 32'h8000_0001, 32'h5555_AAAA, 32'h7777_1111};
   localparam int T_FA [10] = '{-1, -1, 0, 31, 32, 38, 4, 0, 12, 37};
   localparam int T_FB [10] = '{-1, -1, -1, -1, -1, -1, 17, 33, 38, -1};
   localparam logic [1:0] T_ERR [10] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd1};

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8ns * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [BD-1:0] w;
      logic [BW-1:0] d;

      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9 data main", 64'(dat_m), 64'h0);
      check("R9 err main", 64'(err_m), 64'h0);
      check("R9 err sec", 64'(err_s), 64'h0);
      check("R9 err pipe", 64'(err_p), 64'h0);
      @(negedge clk) rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5
      for (int i = 0; i < 10; i++) begin
         w = enc(T_DATA[i]);
         if (T_FA[i] >= 0) w[T_FA[i]] = ~w[T_FA[i]];
         if (T_FB[i] >= 0) w[T_FB[i]] = ~w[T_FB[i]];
         @(negedge clk) cw_d = w;
         repeat (2) @(negedge clk);
         check($sformatf("R2 R3 R4 R5 status vec %0d", i), 64'(err_m), 64'(T_ERR[i]));
         check($sformatf("R3 R4 R5 data vec %0d", i), 64'(dat_m),
               64'((T_ERR[i] == 2'd2) ? w[BW-1:0] : T_DATA[i]));
      end

      // R6 out of range with detection on: d3 (pos 7), check3 (pos 8), check5 (pos 32)
      d = 32'h3C3C_0FF0;
      w = enc(d);
      w[3] = ~w[3];
      w[35] = ~w[35];
      w[37] = ~w[37];
      @(negedge clk) cw_d = w;
      repeat (2) @(negedge clk);
      check("R6 status ded", 64'(err_m), 64'h2);
      check("R6 data ded raw", 64'(dat_m), 64'(d ^ 32'h8));

      // R8 detection off
      d = 32'h0BAD_CAFE;
      w = enc(d);
      w[5] = ~w[5];
      @(negedge clk) cw_s = w[BS-1:0];
      repeat (2) @(negedge clk);
      check("R8 status sec single", 64'(err_s), 64'h1);
      check("R8 data sec corrected", 64'(dat_s), 64'(d));
      w = enc(d);
      @(negedge clk) cw_s = w[BS-1:0];
      repeat (2) @(negedge clk);
      check("R8 status sec clean", 64'(err_s), 64'h0);
      w[34] = ~w[34];
      @(negedge clk) cw_s = w[BS-1:0];
      repeat (2) @(negedge clk);
      check("R4 R8 sec check bit", 64'(err_s), 64'h1);
      check("R4 R8 sec data kept", 64'(dat_s), 64'(d));
      // R6 detection off: check3 + check5 -> syndrome 40
      w = enc(d);
      w[35] = ~w[35];
      w[37] = ~w[37];
      @(negedge clk) cw_s = w[BS-1:0];
      repeat (2) @(negedge clk);
      check("R6 status sec", 64'(err_s), 64'h2);
      check("R6 data sec raw", 64'(dat_s), 64'(d));

      // R7 latency
      @(negedge clk) cw_d = '0;
      repeat (4) @(negedge clk);
      d = 32'h6666_9999;
      w = enc(d);
      w[0] = ~w[0];
      cw_d = w;
      @(negedge clk);
      check("R7 main not early", 64'(err_m), 64'h0);
      cw_d = '0;
      @(negedge clk);
      check("R7 main at two", 64'(err_m), 64'h1);
      check("R7 main data at two", 64'(dat_m), 64'(d));
      check("R7 pipe not early", 64'(err_p), 64'h0);
      @(negedge clk);
      check("R7 pipe at three", 64'(err_p), 64'h1);
      check("R7 pipe data at three", 64'(dat_p), 64'(d));
      check("R7 main back to clean", 64'(err_m), 64'h0);

      // R10 back-to-back stream
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check($sformatf("R10 stream data %0d", i - 2), 64'(dat_m), 64'(32'h1111_1111 * (i - 1)));
            check($sformatf("R10 stream err %0d", i - 2), 64'(err_m), 64'h1);
         end
         if (i < 4) begin
            w = enc(32'h1111_1111 * (i + 1));
            w[i * 7] = ~w[i * 7];
            cw_d = w;
         end
      end

      // R9 asynchronous reset mid-run
      d = 32'hFACE_0001;
      cw_d = enc(d);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 async data", 64'(dat_m), 64'h0);
      check("R9 async pipe data", 64'(dat_p), 64'h0);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule